// File: doc/BRIEF.md
# Shared Word-Memory Access Port

This block gives an internal bus-master engine access to a 16-bit word memory that other agents also use. The engine hands over one command at a time (read or write, word address, write data and a per-byte lane mask). The port then asks for the memory with an active-low request and waits for an active-low grant. Once it owns the bus it runs the access and returns a one-cycle completion pulse, together with the captured word for reads. If a further command is waiting when an access ends, the port accepts it in that same cycle and keeps the request asserted without a gap.

Two timing modes are offered. The mode is latched once after reset. Synchronous mode suits on-chip RAM: the strobe falls in the first owned cycle. Write data is taken on the rising edge that closes the strobe, and read data is captured on that same edge. Asynchronous mode suits external static RAM: one setup cycle puts out address and chip select with the strobes high, then the strobe phase runs, then one hold cycle keeps address and select with the strobes high. In both modes an active wait input stretches the strobe.

A grant watchdog counts the cycles spent requesting without a grant. When the programmed limit is reached, the port raises a failure flag. It then stays inert until reset.

Top module: `shared_mem_port`

## Requirements
- R1: During and after reset, with no command given, request, chip select, read strobe and both write strobe bits are high, control-enable, data-enable, failure and done are low.
- R2: Request goes low in the cycle after a command is accepted and stays low until the final access cycle; when a new command is accepted in that final cycle, request stays low without a high cycle between the two accesses.
- R3: In synchronous mode the strobe is low in the first cycle after a grant is sampled; a read captures the data input on the rising edge that ends the last strobe cycle, and done pulses for exactly one cycle after that edge with the captured word on the read-data output.
- R4: A write drives write-strobe bit 1 low only when lane-mask bit 1 is 1 (upper byte, data 15:8) and bit 0 low only when lane-mask bit 0 is 1 (lower byte, data 7:0); read and write strobes are never low together.
- R5: In asynchronous mode each access has exactly one cycle with chip select low and strobes high before the strobe phase and exactly one such cycle after it, so chip select is low for the strobe length plus two cycles.
- R6: In asynchronous mode a read captures the data present on the last strobe cycle, the one in which the read strobe is about to rise.
- R7: Every rising edge that samples wait low while a strobe is low leaves the strobe low for one more cycle, so the strobe lasts one cycle plus the number of wait-low samples.
- R8: Chip select is low exactly while the port owns the bus, and it is low whenever a strobe is low; the address (and write data) does not change while chip select stays low.
- R9: Control-enable is high exactly while chip select is low, and data-enable is high only while control-enable is high and the access is a write.
- R10: When grant has been sampled high on as many consecutive requesting edges as the limit input (a limit of 0 acts as 1), failure goes high, request returns high, and commands are refused; this holds until reset. A grant sampled low on the edge that would reach the limit wins, and the access proceeds.
- R11: The mode input is latched in the first cycle after reset release, and commands are refused in that cycle; later changes to the mode input have no effect on access timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cfg_async | input | 1 | Timing mode, 1 = asynchronous (latched after reset) |
| cfg_gnt_limit | input | TMR_W | Grant watchdog limit in cycles |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_bmask | input | DATA_W/8 | Lane enables, bit i = byte i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last captured read word |
| mem_req_n | output | 1 | Bus request, active low |
| mem_gnt_n | input | 1 | Bus grant, active low, clock-synchronous |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | DATA_W/8 | Per-lane write strobes, active low |
| mem_wait_n | input | 1 | Wait, active low, stretches the strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Memory write data |
| mem_din | input | DATA_W | Memory read data |
| mem_ctl_en | output | 1 | Enable for control/address drivers |
| mem_dat_en | output | 1 | Enable for data drivers during writes |
| mem_fail | output | 1 | Grant watchdog failure, sticky |

## Verification
Two pairs of functions can land on the same cycle. The first is the grant watchdog reaching its limit in the cycle a grant finally arrives. The bench holds grant high for one cycle fewer than the limit and drops it on the limit edge, then expects a normal access with no failure. One more high cycle must give the sticky failure. The second is command acceptance falling on the final strobe cycle of the previous access. Two reads are queued back to back, and the bench judges it by a request line that never rises between them, two separate done pulses, and each pulse returning the word present on its own strobe.

// File: rtl/smp_pkg.sv
package smp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_SETUP = 3'd2,
    ST_STRB  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_HALT  = 3'd5
  } smp_state_e;

endpackage

// File: rtl/smp_rst_sync.sv
module smp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;

endmodule

// File: rtl/smp_grant_timer.sv
module smp_grant_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             waiting,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);

  localparam int EXT_W = TMR_W + 1;

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] next_ext;
  logic [EXT_W-1:0] lim_ext;

  always_comb begin
    next_ext = {1'b0, cnt_q} + EXT_W'(1);
    lim_ext  = {1'b0, limit};
    expire   = active && waiting && (next_ext >= lim_ext);
    cnt_en   = active ? waiting : (cnt_q != '0);
    cnt_d    = active ? next_ext[TMR_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/smp_seq.sv
module smp_seq
  import smp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_async,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LANES-1:0]  cmd_bmask,
  input  logic              mem_gnt_n,
  input  logic              mem_wait_n,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              tmr_expire,
  output smp_state_e        state_q,
  output logic              mode_q,
  output logic              cmd_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q
);

  smp_state_e state_d;
  logic       cfg_ok_q;
  logic       last_cyc;
  logic       load;
  logic       capture;

  always_comb begin
    last_cyc  = ((state_q == ST_STRB) && mem_wait_n && !mode_q) ||
                (state_q == ST_HOLD);
    cmd_ready = cfg_ok_q && ((state_q == ST_IDLE) || last_cyc);
    load      = cmd_ready && cmd_valid;
    capture   = (state_q == ST_STRB) && mem_wait_n && !wr_q;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_REQ;
      ST_REQ: begin
        if (!mem_gnt_n)      state_d = mode_q ? ST_SETUP : ST_STRB;
        else if (tmr_expire) state_d = ST_HALT;
      end
      ST_SETUP: state_d = ST_STRB;
      ST_STRB: begin
        if (mem_wait_n) begin
          if (mode_q)    state_d = ST_HOLD;
          else if (load) state_d = ST_REQ;
          else           state_d = ST_IDLE;
        end
      end
      ST_HOLD:  state_d = load ? ST_REQ : ST_IDLE;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ok_q <= 1'b0;
      mode_q   <= 1'b0;
    end else if (!cfg_ok_q) begin
      cfg_ok_q <= 1'b1;
      mode_q   <= cfg_async;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (load) begin
      wr_q    <= cmd_write;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
      mask_q  <= cmd_bmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= mem_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done <= 1'b0;
    end else begin
      rsp_done <= last_cyc;
    end
  end

endmodule

// File: rtl/smp_pins.sv
module smp_pins
  import smp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  smp_state_e        state_q,
  input  logic              wr_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [LANES-1:0]  mask_q,
  output logic              mem_req_n,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic [LANES-1:0]  mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_ctl_en,
  output logic              mem_dat_en,
  output logic              mem_fail
);

  logic owned;
  logic strobe;

  always_comb begin
    owned      = (state_q == ST_SETUP) || (state_q == ST_STRB) ||
                 (state_q == ST_HOLD);
    strobe     = (state_q == ST_STRB);
    mem_req_n  = !(owned || (state_q == ST_REQ));
    mem_cs_n   = !owned;
    mem_rd_n   = !(strobe && !wr_q);
    mem_ctl_en = owned;
    mem_dat_en = owned && wr_q;
    mem_fail   = (state_q == ST_HALT);
    mem_addr   = addr_q;
    mem_dout   = wdata_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mem_wr_n[i] = !(strobe && wr_q && mask_q[i]);
  end

endmodule

// File: rtl/shared_mem_port.sv
module shared_mem_port
  import smp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TMR_W  = 8,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cfg_async,
  input  logic [TMR_W-1:0]  cfg_gnt_limit,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LANES-1:0]  cmd_bmask,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_n,
  input  logic              mem_gnt_n,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic [LANES-1:0]  mem_wr_n,
  input  logic              mem_wait_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ctl_en,
  output logic              mem_dat_en,
  output logic              mem_fail
);

  logic              rst_n_s;
  smp_state_e        state_q;
  logic              mode_q;
  logic              tmr_expire;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  smp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_s (rst_n_s)
  );

  smp_grant_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .active  (state_q == ST_REQ),
    .waiting (mem_gnt_n),
    .limit   (cfg_gnt_limit),
    .expire  (tmr_expire)
  );

  smp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_async  (cfg_async),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .cmd_bmask  (cmd_bmask),
    .mem_gnt_n  (mem_gnt_n),
    .mem_wait_n (mem_wait_n),
    .mem_din    (mem_din),
    .tmr_expire (tmr_expire),
    .state_q    (state_q),
    .mode_q     (mode_q),
    .cmd_ready  (cmd_ready),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .wr_q       (wr_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .mask_q     (mask_q)
  );

  smp_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .state_q    (state_q),
    .wr_q       (wr_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .mask_q     (mask_q),
    .mem_req_n  (mem_req_n),
    .mem_cs_n   (mem_cs_n),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_ctl_en (mem_ctl_en),
    .mem_dat_en (mem_dat_en),
    .mem_fail   (mem_fail)
  );

endmodule

// File: rtl/smp_port_chk.sv
module smp_port_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_async,
  input logic              cmd_ready,
  input logic              rsp_done,
  input logic              mem_req_n,
  input logic              mem_gnt_n,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic [LANES-1:0]  mem_wr_n,
  input logic              mem_wait_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ctl_en,
  input logic              mem_dat_en,
  input logic              mem_fail
);

  logic any_wr;
  logic any_strb;
  assign any_wr   = (mem_wr_n != {LANES{1'b1}});
  assign any_strb = any_wr || !mem_rd_n;

  p_strobe_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_wr && !mem_rd_n));

  p_strobe_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |-> !mem_cs_n);

  p_addr_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_wait_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && !mem_wait_n) |=> !mem_rd_n);

  p_wait_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !mem_wait_n) |=> $stable(mem_wr_n));

  p_async_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_async && $fell(mem_rd_n)) |-> $past(!mem_cs_n));

  p_async_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_async && $rose(mem_rd_n)) |-> !mem_cs_n);

  p_den_in_cen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dat_en |-> (mem_ctl_en && !mem_req_n));

  p_cen_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ctl_en |-> !mem_cs_n);

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fail |=> mem_fail);

  p_fail_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fail |-> (mem_req_n && mem_cs_n && !cmd_ready));

  p_fail_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_fail) |-> $past(!mem_req_n && mem_gnt_n));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind shared_mem_port smp_port_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .mode_async (mode_q),
  .cmd_ready  (cmd_ready),
  .rsp_done   (rsp_done),
  .mem_req_n  (mem_req_n),
  .mem_gnt_n  (mem_gnt_n),
  .mem_cs_n   (mem_cs_n),
  .mem_rd_n   (mem_rd_n),
  .mem_wr_n   (mem_wr_n),
  .mem_wait_n (mem_wait_n),
  .mem_addr   (mem_addr),
  .mem_ctl_en (mem_ctl_en),
  .mem_dat_en (mem_dat_en),
  .mem_fail   (mem_fail)
);

// File: tb/shared_mem_port_test.sv
module shared_mem_port_test;

  localparam int CLK_P = 10;

  logic        clk;
  logic        arst_n;
  logic        cfg_async;
  logic [7:0]  cfg_gnt_limit;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_write;
  logic [15:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic [1:0]  cmd_bmask;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mem_req_n;
  logic        mem_gnt_n;
  logic        mem_cs_n;
  logic        mem_rd_n;
  logic [1:0]  mem_wr_n;
  logic        mem_wait_n;
  logic [15:0] mem_addr;
  logic [15:0] mem_dout;
  logic [15:0] mem_din;
  logic        mem_ctl_en;
  logic        mem_dat_en;
  logic        mem_fail;

  int n_chk;
  int n_err;

  shared_mem_port uut (
    .clk(clk), .arst_n(arst_n), .cfg_async(cfg_async), .cfg_gnt_limit(cfg_gnt_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_bmask(cmd_bmask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_req_n(mem_req_n),
    .mem_gnt_n(mem_gnt_n), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_wait_n(mem_wait_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_ctl_en(mem_ctl_en),
    .mem_dat_en(mem_dat_en), .mem_fail(mem_fail)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  mask;
    logic [3:0]  waits;
    logic [3:0]  gdly;
    logic [15:0] din;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0010, 16'h0000, 2'b00, 4'd0, 4'd0, 16'hBEEF},
    '{1'b1, 16'h0020, 16'hA5C3, 2'b11, 4'd0, 4'd1, 16'h0000},
    '{1'b1, 16'h0030, 16'h1234, 2'b10, 4'd2, 4'd0, 16'h0000},
    '{1'b1, 16'h0031, 16'h5678, 2'b01, 4'd1, 4'd2, 16'h0000},
    '{1'b0, 16'hFFFE, 16'h0000, 2'b00, 4'd3, 4'd3, 16'h6C01},
    '{1'b0, 16'h8001, 16'h0000, 2'b00, 4'd5, 4'd0, 16'h0F0F}
  };

  function automatic void chk(input bit ok, input string req,
                              input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  task automatic do_reset(input logic async_m, input logic [7:0] lim);
    arst_n        = 1'b0;
    cfg_async     = async_m;
    cfg_gnt_limit = lim;
    cmd_valid     = 1'b0;
    cmd_write     = 1'b0;
    cmd_addr      = '0;
    cmd_wdata     = '0;
    cmd_bmask     = '0;
    mem_gnt_n     = 1'b1;
    mem_wait_n    = 1'b1;
    mem_din       = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_acc(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                         input logic [1:0] m, input int waits, input int gdly,
                         input logic [15:0] dv,
                         output int nst, output logic [1:0] wro, output logic [15:0] rd,
                         output bit fl, output int cscnt, output bit fst, output bit lst,
                         output bit busok, output bit fin);
    int  rq;
    bit  seen_cs;
    bit  stb;
    nst = 0; wro = 2'b11; rd = '0; fl = 0; cscnt = 0; fst = 0; lst = 0;
    busok = 1; fin = 0; rq = 0; seen_cs = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_bmask = m;
    mem_wait_n = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int it = 0; it < 80; it++) begin
      if (mem_fail) begin fl = 1; break; end
      if (rsp_done) begin rd = rsp_rdata; fin = 1; break; end
      stb = !mem_rd_n || (mem_wr_n != 2'b11);
      if (!mem_req_n && mem_cs_n) begin
        if (mem_ctl_en) busok = 0;
        mem_gnt_n = (rq >= gdly) ? 1'b0 : 1'b1;
        rq++;
      end
      if (!mem_cs_n) begin
        if (!seen_cs) fst = stb;
        seen_cs = 1;
        lst = stb;
        cscnt++;
        if (!mem_ctl_en || (mem_dat_en != wr) || (mem_addr != a)) busok = 0;
        if (wr && (mem_dout != wd)) busok = 0;
      end
      if (stb) begin
        nst++;
        wro = mem_wr_n;
        mem_wait_n = (nst <= waits) ? 1'b0 : 1'b1;
        mem_din    = mem_wait_n ? dv : ~dv;
      end else begin
        mem_wait_n = 1'b1;
        mem_din    = ~dv;
      end
      @(negedge clk);
    end
    mem_gnt_n  = 1'b1;
    mem_wait_n = 1'b1;
  endtask

  int          nst, cscnt;
  logic [1:0]  wro;
  logic [15:0] rd;
  bit          fl, fst, lst, busok, fin;

  initial begin
    #(CLK_P * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_err = 0;

    // R1: reset state
    arst_n = 1'b0; cfg_async = 1'b0; cfg_gnt_limit = 8'd8;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0; cmd_bmask = '0;
    mem_gnt_n = 1'b1; mem_wait_n = 1'b1; mem_din = '0;
    repeat (2) @(negedge clk);
    chk(mem_req_n && mem_cs_n && mem_rd_n && (mem_wr_n == 2'b11) &&
        !mem_ctl_en && !mem_dat_en && !mem_fail && !rsp_done, "R1 in reset",
        {mem_req_n, mem_cs_n, mem_rd_n, mem_wr_n, mem_ctl_en, mem_dat_en, mem_fail, rsp_done},
        32'b111110000);
    arst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R11: first cycle after sync release refuses commands
    cmd_valid = 1'b1;
    chk(!cmd_ready, "R11 ready during mode latch", cmd_ready, 0);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_req_n && mem_cs_n && !mem_fail && !rsp_done, "R1 idle after reset",
        {mem_req_n, mem_cs_n, mem_fail, rsp_done}, 4'b1100);

    // Synchronous mode vector walk: R3 R4 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      run_acc(VECS[v].wr, VECS[v].addr, VECS[v].wdata, VECS[v].mask,
              int'(VECS[v].waits), int'(VECS[v].gdly), VECS[v].din,
              nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
      chk(fin && !fl, "R3 access completes", {fin, fl}, 2'b10);
      chk(nst == int'(VECS[v].waits) + 1, "R7 strobe length", nst, VECS[v].waits + 1);
      chk(fst && lst && (cscnt == nst), "R3 no setup or hold in sync mode",
          cscnt, nst);
      chk(busok, "R9 enables, address and data while owned", busok, 1);
      if (VECS[v].wr)
        chk(wro == ~VECS[v].mask, "R4 lane strobes", wro, ~VECS[v].mask);
      else
        chk(rd == VECS[v].din, "R3 read capture", rd, VECS[v].din);
    end

    // R11: mode input changed after latch has no effect
    cfg_async = 1'b1;
    run_acc(1'b0, 16'h0042, 16'h0, 2'b00, 1, 0, 16'h3C3C,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fst && (cscnt == nst) && (rd == 16'h3C3C), "R11 sync timing kept", cscnt, nst);

    // R2: back-to-back reads keep request low
    begin
      bit rq_hi;
      int dones;
      rq_hi = 0; dones = 0;
      @(negedge clk);
      mem_gnt_n = 1'b0; mem_wait_n = 1'b1;
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0100; cmd_bmask = 2'b00;
      @(negedge clk);                 // c1: REQ
      cmd_addr = 16'h0200; mem_din = 16'h1111;
      if (mem_req_n) rq_hi = 1;
      @(negedge clk);                 // c2: strobe A, ready
      chk(cmd_ready && !mem_rd_n && (mem_addr == 16'h0100), "R2 accept on last strobe",
          {cmd_ready, mem_rd_n}, 2'b10);
      if (mem_req_n) rq_hi = 1;
      @(negedge clk);                 // c3: REQ, done A
      cmd_valid = 1'b0; mem_din = 16'h2222;
      if (mem_req_n) rq_hi = 1;
      if (rsp_done) dones++;
      chk(rsp_done && (rsp_rdata == 16'h1111), "R2 first done data", rsp_rdata, 16'h1111);
      @(negedge clk);                 // c4: strobe B
      if (mem_req_n) rq_hi = 1;
      chk(!mem_rd_n && (mem_addr == 16'h0200), "R2 second address", mem_addr, 16'h0200);
      @(negedge clk);                 // c5: idle, done B
      if (rsp_done) dones++;
      chk(!rq_hi && mem_req_n, "R2 request continuous then released",
          {rq_hi, mem_req_n}, 2'b01);
      chk(dones == 2 && (rsp_rdata == 16'h2222), "R2 second done data", rsp_rdata, 16'h2222);
      mem_gnt_n = 1'b1;
    end

    // R10: grant on the limit edge wins
    do_reset(1'b0, 8'd4);
    run_acc(1'b0, 16'h0005, 16'h0, 2'b00, 0, 3, 16'h7777,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fin && !fl && (rd == 16'h7777), "R10 grant at limit proceeds", {fin, fl}, 2'b10);

    // R10: timeout fails, sticky, refuses commands
    run_acc(1'b1, 16'h0006, 16'h9999, 2'b11, 0, 4, 16'h0,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fl && (nst == 0), "R10 failure on timeout", {fl, nst[0]}, 2'b10);
    cmd_valid = 1'b1; mem_gnt_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_fail && mem_req_n && mem_cs_n && !cmd_ready && mem_rd_n && (mem_wr_n == 2'b11),
        "R10 failure sticky and inert", {mem_fail, mem_req_n, cmd_ready}, 3'b110);
    cmd_valid = 1'b0; mem_gnt_n = 1'b1;

    // R10: limit 0 behaves as 1
    do_reset(1'b0, 8'd0);
    run_acc(1'b0, 16'h0007, 16'h0, 2'b00, 0, 1, 16'h0,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fl, "R10 zero limit", fl, 1);
    do_reset(1'b0, 8'd0);
    run_acc(1'b0, 16'h0008, 16'h0, 2'b00, 0, 0, 16'h4321,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fin && !fl, "R10 zero limit immediate grant", {fin, fl}, 2'b10);

    // Asynchronous mode: R5 R6 R7 R11
    do_reset(1'b1, 8'd8);
    cfg_async = 1'b0;
    run_acc(1'b0, 16'h1357, 16'h0, 2'b00, 2, 1, 16'hCAFE,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fin && !fst && !lst && (cscnt == nst + 2), "R5 setup and hold cycles",
        cscnt, nst + 2);
    chk(nst == 3, "R7 async strobe length", nst, 3);
    chk(rd == 16'hCAFE, "R6 async read at strobe rise", rd, 16'hCAFE);
    chk(busok, "R8 address held while selected", busok, 1);
    run_acc(1'b1, 16'h2468, 16'hD00D, 2'b01, 0, 0, 16'h0,
            nst, wro, rd, fl, cscnt, fst, lst, busok, fin);
    chk(fin && !fst && !lst && (cscnt == 3) && (nst == 1), "R11 async kept after input change",
        cscnt, 3);
    chk((wro == 2'b10) && busok, "R4 lower lane only", wro, 2'b10);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule